// File: doc/BRIEF.md
# Stereo ADC Serial Output Port

This block takes a left and a right 18-bit converter sample and sends them one bit at a time on a single data line. A left/right clock tells the receiver which channel is on the line, and a frame sync marks where each word starts. All logic runs on the converter's master clock `clk`. In master operation the block makes the shift clock, the left/right clock and the frame sync itself. In slave operation a host drives these three signals, and the block samples them on `clk`.

A 3-bit mode code selects three things together: which side drives the clocks, the word length (16 or 18 bits) and the bit order. A ratio select sets how many master-clock cycles make one sample period. A power-down input forces every output low. Samples arrive in parallel with a one-cycle valid strobe, and the block keeps the most recent pair. Each channel word is taken from that held pair at the moment the word starts. Mode and ratio select are changed only while reset is asserted.

Top module: `stereo_adc_port`

## Requirements
- R1: Mode decode. Codes 000, 001 and 010 are slave; codes 011 to 111 are master, and `drive_clocks` is high exactly in master codes. Word length is 16 bits for 011, 110 and 111, and 18 bits otherwise. Bit order is LSB first for 001, 101 and 111, and MSB first otherwise.
- R2: In master mode `sclk_out` has a period of DIV `clk` cycles (default 4). It is low for the first DIV/2 cycles of each period and high for the rest. `sdata_out` changes only on the cycle where `sclk_out` falls.
- R3: In master mode one sample period is 256 `clk` cycles when `ratio_hi` is 0 and 384 cycles when it is 1. `lrck_out` is high for the first half (left channel) and low for the second half (right channel). The left half comes first after reset or power-down.
- R4: In master mode `fsync_out` is high for exactly the first shift-clock period of each half.
- R5: Data bit k of a word (k counted from 0) is sent in shift period k+1 of the half. With an 18-bit word, MSB first sends sample bit 17-k and LSB first sends sample bit k. With a 16-bit word only sample bits 17..2 are used: MSB first sends bit 17-k and LSB first sends bit 2+k. Every shift period after the last data bit carries 0.
- R6: A valid strobe stores both samples. A word takes the channel's sample held before the cycle in which the word starts. A strobe in that same cycle applies only to later words.
- R7: In slave codes 000 and 001, a word starts at the first falling edge of `sclk_in` at which `lrck_in` differs from its value at the previous falling edge. `lrck_in` high selects the left sample. Each falling edge puts the next bit on `sdata_out`, and bits past the word length are 0.
- R8: In slave code 010, bits are sent only at falling edges of `sclk_in` where `fsync_in` is high. The first such edge starts a word for the channel given by `lrck_in`. A falling edge with `fsync_in` low drives `sdata_out` to 0 and restarts the word.
- R9: In slave codes, `sclk_out`, `lrck_out` and `fsync_out` stay low.
- R10: While `pwr_down` is high, all four serial outputs are low from the next cycle on. On release, master timing restarts at the left-half frame start and slave word tracking restarts.
- R11: After synchronous reset, all serial outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 3 | Operating mode code |
| ratio_hi | input | 1 | 1: 384 clocks per sample, 0: 256 |
| pwr_down | input | 1 | Force outputs idle and stop timing |
| left_smp | input | 18 | Left channel sample |
| right_smp | input | 18 | Right channel sample |
| smp_valid | input | 1 | One-cycle strobe storing both samples |
| sclk_in | input | 1 | Host shift clock (slave) |
| lrck_in | input | 1 | Host left/right clock (slave) |
| fsync_in | input | 1 | Host frame sync (slave) |
| sclk_out | output | 1 | Generated shift clock (master) |
| lrck_out | output | 1 | Generated left/right clock (master) |
| fsync_out | output | 1 | Generated frame sync (master) |
| sdata_out | output | 1 | Serial data |
| drive_clocks | output | 1 | High when the clock pins are driven by this block |

## Verification
Two events can fall in the same cycle: a channel word starting, which loads the word register, and a new sample strobe, which updates the held pair. The bench strobes valid every 64 cycles counted from the first active cycle, so the strobes land exactly on the master word boundaries at 128 and 192 cycles. The reference model must then send the sample held before the strobe (R6). A second collision happens when power-down is raised in the middle of a word: the model expects the outputs to go idle on the next cycle and the timing to restart at a left-half start.

// File: rtl/ssp_pkg.sv
package ssp_pkg;

    localparam int SAMPLE_W = 18;
    localparam int SHORT_W  = 16;
    localparam int IDX_W    = 6;

    typedef struct packed {
        logic master;
        logic lsb_first;
        logic short_word;
        logic sync_ctrl;
    } port_cfg_t;

    function automatic port_cfg_t decode_mode(input logic [2:0] m);
        port_cfg_t c;
        c = '{master: 1'b0, lsb_first: 1'b0, short_word: 1'b0, sync_ctrl: 1'b0};
        case (m)
            3'b000: c.sync_ctrl  = 1'b0;
            3'b001: c.lsb_first  = 1'b1;
            3'b010: c.sync_ctrl  = 1'b1;
            3'b011: begin c.master = 1'b1; c.short_word = 1'b1; end
            3'b100: c.master = 1'b1;
            3'b101: begin c.master = 1'b1; c.lsb_first = 1'b1; end
            3'b110: begin c.master = 1'b1; c.short_word = 1'b1; end
            default: begin c.master = 1'b1; c.short_word = 1'b1; c.lsb_first = 1'b1; end
        endcase
        return c;
    endfunction

    function automatic logic pick_bit(input logic [SAMPLE_W-1:0] s,
                                      input logic [IDX_W-1:0] k,
                                      input port_cfg_t c);
        int w;
        int ki;
        w  = c.short_word ? SHORT_W : SAMPLE_W;
        ki = int'(k);
        if (ki >= w) return 1'b0;
        return c.lsb_first ? s[SAMPLE_W - w + ki] : s[SAMPLE_W - 1 - ki];
    endfunction

endpackage

// File: rtl/ssp_master_gen.sv
module ssp_master_gen
    import ssp_pkg::*;
#(
    parameter int DIV      = 4,
    parameter int RATIO_LO = 256,
    parameter int RATIO_HI = 384
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             ratio_hi,
    output logic             sclk_lvl,
    output logic             fsync_lvl,
    output logic             left_lvl,
    output logic             load_word,
    output logic             bit_en,
    output logic [IDX_W-1:0] bit_idx
);
    localparam int PH_W    = (DIV > 1) ? $clog2(DIV) : 1;
    localparam int HALF_LO = RATIO_LO / (2 * DIV);
    localparam int HALF_HI = RATIO_HI / (2 * DIV);
    localparam int SLOT_W  = (HALF_HI > 1) ? $clog2(HALF_HI) : 1;

    logic [PH_W-1:0]   phase_q;
    logic [SLOT_W-1:0] slot_q;
    logic              left_q;
    logic [SLOT_W-1:0] slot_m1;
    int                half_lim;

    assign half_lim = ratio_hi ? HALF_HI : HALF_LO;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            phase_q <= '0;
            slot_q  <= '0;
            left_q  <= 1'b1;
        end else if (int'(phase_q) == DIV - 1) begin
            phase_q <= '0;
            if (int'(slot_q) == half_lim - 1) begin
                slot_q <= '0;
                left_q <= ~left_q;
            end else begin
                slot_q <= slot_q + SLOT_W'(1);
            end
        end else begin
            phase_q <= phase_q + PH_W'(1);
        end
    end

    always_comb begin
        slot_m1   = slot_q - SLOT_W'(1);
        sclk_lvl  = int'(phase_q) >= DIV / 2;
        fsync_lvl = (slot_q == '0);
        left_lvl  = left_q;
        load_word = run && (phase_q == '0) && (slot_q == '0);
        bit_en    = (slot_q != '0);
        bit_idx   = (int'(slot_m1) > (2 ** IDX_W) - 1) ? '1 : IDX_W'(slot_m1);
    end

    a_r4_flip_at_start: assert property (@(posedge clk) disable iff (rst)
        run && $past(run) && $changed(left_q) |-> (slot_q == '0) && (phase_q == '0));

endmodule

// File: rtl/ssp_slave_track.sv
module ssp_slave_track
    import ssp_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             sync_ctrl,
    input  logic             sclk_in,
    input  logic             lrck_in,
    input  logic             fsync_in,
    output logic             fall,
    output logic             start,
    output logic             quiet,
    output logic             chan_left,
    output logic [IDX_W-1:0] idx
);
    logic             sclk_q;
    logic             lr_seen;
    logic [IDX_W-1:0] idx_q;

    always_comb begin
        fall      = run && sclk_q && !sclk_in;
        chan_left = lrck_in;
        if (sync_ctrl) begin
            quiet = !fsync_in;
            start = fsync_in && (idx_q == '0);
            idx   = idx_q;
        end else begin
            quiet = 1'b0;
            start = (lrck_in != lr_seen);
            idx   = start ? '0 : idx_q;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) sclk_q <= 1'b0;
        else     sclk_q <= sclk_in;
    end

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            lr_seen <= 1'b0;
            idx_q   <= '0;
        end else if (fall) begin
            lr_seen <= lrck_in;
            if (quiet)           idx_q <= '0;
            else if (idx == '1)  idx_q <= idx;
            else                 idx_q <= idx + IDX_W'(1);
        end
    end

endmodule

// File: rtl/ssp_word_path.sv
module ssp_word_path
    import ssp_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  port_cfg_t           cfg,
    input  logic                pwr_down,
    input  logic [SAMPLE_W-1:0] left_smp,
    input  logic [SAMPLE_W-1:0] right_smp,
    input  logic                smp_valid,
    input  logic                load,
    input  logic                load_left,
    input  logic                upd,
    input  logic                bit_en,
    input  logic [IDX_W-1:0]    bit_idx,
    output logic                dout
);
    logic [SAMPLE_W-1:0] hold_l, hold_r, word_q, new_word, cur_word;
    logic                dout_next;

    always_comb begin
        new_word  = load_left ? hold_l : hold_r;
        cur_word  = load ? new_word : word_q;
        dout_next = bit_en ? pick_bit(cur_word, bit_idx, cfg) : 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_l <= '0;
            hold_r <= '0;
            word_q <= '0;
            dout   <= 1'b0;
        end else begin
            if (smp_valid) begin
                hold_l <= left_smp;
                hold_r <= right_smp;
            end
            if (load) word_q <= new_word;
            if (pwr_down) dout <= 1'b0;
            else if (upd) dout <= dout_next;
        end
    end

endmodule

// File: rtl/stereo_adc_port.sv
module stereo_adc_port
    import ssp_pkg::*;
#(
    parameter int DIV      = 4,
    parameter int RATIO_LO = 256,
    parameter int RATIO_HI = 384
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [2:0]          mode,
    input  logic                ratio_hi,
    input  logic                pwr_down,
    input  logic [SAMPLE_W-1:0] left_smp,
    input  logic [SAMPLE_W-1:0] right_smp,
    input  logic                smp_valid,
    input  logic                sclk_in,
    input  logic                lrck_in,
    input  logic                fsync_in,
    output logic                sclk_out,
    output logic                lrck_out,
    output logic                fsync_out,
    output logic                sdata_out,
    output logic                drive_clocks
);
    port_cfg_t        cfg;
    logic             m_run, s_run, m_run_q;
    logic             m_sclk, m_fsync, m_left, m_load, m_bit_en;
    logic [IDX_W-1:0] m_idx;
    logic             s_fall, s_start, s_quiet, s_left;
    logic [IDX_W-1:0] s_idx;
    logic             w_load, w_left, w_upd, w_bit_en;
    logic [IDX_W-1:0] w_idx;

    assign cfg          = decode_mode(mode);
    assign m_run        = cfg.master && !pwr_down;
    assign s_run        = !cfg.master && !pwr_down;
    assign drive_clocks = cfg.master;

    ssp_master_gen #(.DIV(DIV), .RATIO_LO(RATIO_LO), .RATIO_HI(RATIO_HI)) u_mgen (
        .clk(clk), .rst(rst), .run(m_run), .ratio_hi(ratio_hi),
        .sclk_lvl(m_sclk), .fsync_lvl(m_fsync), .left_lvl(m_left),
        .load_word(m_load), .bit_en(m_bit_en), .bit_idx(m_idx)
    );

    ssp_slave_track u_strk (
        .clk(clk), .rst(rst), .run(s_run), .sync_ctrl(cfg.sync_ctrl),
        .sclk_in(sclk_in), .lrck_in(lrck_in), .fsync_in(fsync_in),
        .fall(s_fall), .start(s_start), .quiet(s_quiet),
        .chan_left(s_left), .idx(s_idx)
    );

    always_comb begin
        if (cfg.master) begin
            w_load   = m_load;
            w_left   = m_left;
            w_upd    = m_run;
            w_bit_en = m_bit_en;
            w_idx    = m_idx;
        end else begin
            w_load   = s_fall && s_start && !s_quiet;
            w_left   = s_left;
            w_upd    = s_fall;
            w_bit_en = !s_quiet;
            w_idx    = s_idx;
        end
    end

    ssp_word_path u_word (
        .clk(clk), .rst(rst), .cfg(cfg), .pwr_down(pwr_down),
        .left_smp(left_smp), .right_smp(right_smp), .smp_valid(smp_valid),
        .load(w_load), .load_left(w_left), .upd(w_upd),
        .bit_en(w_bit_en), .bit_idx(w_idx), .dout(sdata_out)
    );

    always_ff @(posedge clk) begin
        if (rst || !m_run) begin
            sclk_out  <= 1'b0;
            lrck_out  <= 1'b0;
            fsync_out <= 1'b0;
            m_run_q   <= 1'b0;
        end else begin
            sclk_out  <= m_sclk;
            lrck_out  <= m_left;
            fsync_out <= m_fsync;
            m_run_q   <= 1'b1;
        end
    end

    a_r10_pd_idle: assert property (@(posedge clk) disable iff (rst)
        pwr_down |=> (!sdata_out && !sclk_out && !lrck_out && !fsync_out));

    a_r9_slave_clocks_low: assert property (@(posedge clk) disable iff (rst)
        !cfg.master |=> (!sclk_out && !lrck_out && !fsync_out));

    a_r2_data_on_fall: assert property (@(posedge clk) disable iff (rst)
        m_run_q && $past(m_run_q) && $changed(sdata_out) |-> $fell(sclk_out));

    a_r3_lr_edge_sync: assert property (@(posedge clk) disable iff (rst)
        m_run_q && $changed(lrck_out) |-> fsync_out);

    a_r8_quiet_zero: assert property (@(posedge clk) disable iff (rst)
        s_run && s_fall && cfg.sync_ctrl && !fsync_in |=> !sdata_out);

endmodule

// File: tb/sim_stereo_adc_port.sv
module sim_stereo_adc_port;
    localparam int DIV = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  mode = 3'b100;
    logic        ratio_hi = 1'b0, pwr_down = 1'b0, smp_valid = 1'b0;
    logic [17:0] left_smp = '0, right_smp = '0;
    logic        sclk_in = 1'b0, lrck_in = 1'b0, fsync_in = 1'b0;
    logic        sclk_out, lrck_out, fsync_out, sdata_out, drive_clocks;

    always #2 clk = ~clk;

    stereo_adc_port #(.DIV(DIV)) u0 (
        .clk(clk), .rst(rst), .mode(mode), .ratio_hi(ratio_hi), .pwr_down(pwr_down),
        .left_smp(left_smp), .right_smp(right_smp), .smp_valid(smp_valid),
        .sclk_in(sclk_in), .lrck_in(lrck_in), .fsync_in(fsync_in),
        .sclk_out(sclk_out), .lrck_out(lrck_out), .fsync_out(fsync_out),
        .sdata_out(sdata_out), .drive_clocks(drive_clocks)
    );

    int    n_cmp = 0, n_bad = 0;
    string t_clk = "R2", t_lr = "R3", t_fs = "R4", t_dat = "R5";
    logic  check_en = 1'b0;

    // reference model state
    int          n, sidx;
    logic        ps, lrs;
    logic [17:0] word, hl, hr;
    logic        e_sclk, e_lr, e_fs, e_dout;

    function automatic logic bitof(logic [17:0] s, int k, logic [2:0] m);
        int   w;
        logic lsb;
        w   = (m == 3'd3 || m >= 3'd6) ? 16 : 18;
        lsb = (m == 3'd1 || m == 3'd5 || m == 3'd7);
        if (k >= w) return 1'b0;
        return lsb ? s[18 - w + k] : s[17 - k];
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            n = 0; sidx = 0; ps = 0; lrs = 0; word = '0; hl = '0; hr = '0;
            e_sclk = 0; e_lr = 0; e_fs = 0; e_dout = 0;
        end else begin
            if (mode >= 3'd3) begin
                sidx = 0; lrs = 0;
                if (pwr_down) begin
                    n = 0; e_sclk = 0; e_lr = 0; e_fs = 0; e_dout = 0;
                end else begin
                    int half, b, pos, s, ph;
                    logic left;
                    half = (ratio_hi ? 384 : 256) / (2 * DIV);
                    b    = n / DIV;
                    ph   = n % DIV;
                    pos  = b % (2 * half);
                    left = pos < half;
                    s    = pos % half;
                    e_sclk = (ph >= DIV / 2);
                    e_lr   = left;
                    e_fs   = (s == 0);
                    e_dout = (s >= 1) ? bitof(word, s - 1, mode) : 1'b0;
                    if (ph == 0 && s == 0) word = left ? hl : hr;
                    n++;
                end
            end else begin
                n = 0; e_sclk = 0; e_lr = 0; e_fs = 0;
                if (pwr_down) begin
                    sidx = 0; lrs = 0; e_dout = 0;
                end else if (ps && !sclk_in) begin
                    if (mode == 3'd2) begin
                        if (!fsync_in) begin
                            sidx = 0; e_dout = 0;
                        end else begin
                            if (sidx == 0) word = lrck_in ? hl : hr;
                            e_dout = bitof(word, sidx, mode);
                            if (sidx < 63) sidx++;
                        end
                    end else if (lrck_in !== lrs) begin
                        word = lrck_in ? hl : hr;
                        e_dout = bitof(word, 0, mode);
                        sidx = 1;
                    end else begin
                        e_dout = bitof(word, sidx, mode);
                        if (sidx < 63) sidx++;
                    end
                    lrs = lrck_in;
                end
            end
            if (smp_valid) begin hl = left_smp; hr = right_smp; end
        end
        if (rst) ps = 0; else ps = sclk_in;
    end

    task automatic cmp(string req, string nm, logic act, logic exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s act=%b exp=%b t=%0t mode=%b", req, nm, act, exp, $time, mode);
        end
    endtask

    always @(negedge clk) begin
        if (check_en) begin
            cmp(t_clk, "sclk_out", sclk_out, e_sclk);
            cmp(t_lr, "lrck_out", lrck_out, e_lr);
            cmp(t_fs, "fsync_out", fsync_out, e_fs);
            cmp(t_dat, "sdata_out", sdata_out, e_dout);
            if (!rst) cmp("R1", "drive_clocks", drive_clocks, mode >= 3'd3);
        end
    end

    task automatic start(logic [2:0] m, logic r);
        @(negedge clk);
        rst = 1'b1; mode = m; ratio_hi = r; pwr_down = 1'b0; smp_valid = 1'b0;
        sclk_in = 1'b0; lrck_in = 1'b0; fsync_in = 1'b0;
        repeat (3) @(negedge clk);
        // R11: reset state of the serial outputs
        cmp("R11", "rst sclk", sclk_out, 1'b0);
        cmp("R11", "rst lrck", lrck_out, 1'b0);
        cmp("R11", "rst fsync", fsync_out, 1'b0);
        cmp("R11", "rst data", sdata_out, 1'b0);
        check_en = 1'b1;
        rst = 1'b0;
    endtask

    task automatic run(int cycles, bit slave, int seed);
        for (int i = 0; i < cycles; i++) begin
            int bp;
            if (i != 0) @(negedge clk);
            smp_valid = (i % 64 == 0);
            if (smp_valid) begin
                left_smp  = 18'(i * 7919 + seed * 331 + 18'h15A5A);
                right_smp = 18'(~(i * 2749 + seed * 97) ^ 18'h0C3F1);
            end
            if (slave) begin
                bp       = i / 8;
                sclk_in  = (i % 8) >= 4;
                lrck_in  = ((bp / 24) % 2) == 1;
                fsync_in = (mode == 3'd2) ? ((bp % 24) < 20) : 1'b1;
            end
        end
        @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog act=running exp=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        // R5 master orders and widths, R2/R3/R4 timing
        t_clk = "R2"; t_lr = "R3"; t_fs = "R4"; t_dat = "R5";
        start(3'b100, 1'b0); run(900, 0, 1);
        start(3'b101, 1'b1); run(1200, 0, 2);
        start(3'b011, 1'b0); run(700, 0, 3);
        start(3'b111, 1'b1); run(900, 0, 4);
        start(3'b110, 1'b0); run(700, 0, 5);
        // R6 strobes coincide with word starts
        t_dat = "R6";
        start(3'b100, 1'b1); run(900, 0, 6);
        // R10 power-down in master mode, mid-word
        t_clk = "R10"; t_lr = "R10"; t_fs = "R10"; t_dat = "R10";
        start(3'b101, 1'b0); run(301, 0, 7);
        pwr_down = 1'b1; run(40, 0, 8);
        pwr_down = 1'b0; run(600, 0, 9);
        // R7 slave with sync held high, R9 clocks stay low
        t_clk = "R9"; t_lr = "R9"; t_fs = "R9"; t_dat = "R7";
        start(3'b000, 1'b0); run(1600, 1, 10);
        start(3'b001, 1'b0); run(1600, 1, 11);
        // R8 slave with host-controlled sync
        t_dat = "R8";
        start(3'b010, 1'b0); run(2000, 1, 12);
        // R10 power-down in slave mode
        t_dat = "R10";
        start(3'b000, 1'b0); run(500, 1, 13);
        pwr_down = 1'b1; run(60, 1, 14);
        pwr_down = 1'b0; run(800, 1, 15);
        check_en = 1'b0;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule